// File: doc/BRIEF.md
# Partition Write-Protect Controller with Address-Sequence Unlock

This block sits between a host bus and a byte-wide static RAM of 2^ADDR_W bytes. It splits the memory into 16 equal partitions, selected by the top four address bits. For each partition it holds one protect bit. When a write targets a partition whose protect bit is set, the block holds the RAM write strobe inactive. Writes to other partitions pass through unchanged.

The protect bits cannot be written like an ordinary register. The host first sends a fixed sequence of partition nibbles on the top address bits over consecutive read cycles. The sequence is held in a parameter table. The four read cycles that follow the sequence carry the new protect bits, again on the top address bits. A write cycle or a wrong nibble restarts the sequence. A power-fail flag blocks every write, turns off the data drivers, and raises a warning output.

The bus strobes arrive asynchronous to the clock. Each one passes through two flops, and a bus cycle is counted when the synchronized chip enable rises.

Top module: `partprot_ctrl`

## Requirements
- R1: After reset, all 16 protect bits are 0, so `ram_we_n` equals `we_n` for every partition, and `pwr_warn` is 0.
- R2: A bus cycle ends when the synchronized `ce_n` rises. It is a write cycle if the synchronized `we_n` was low at any sampled point while `ce_n` was low. It is a read cycle if the synchronized `oe_n` was low and `we_n` never was. A cycle with neither strobe active is ignored and does not disturb the matcher.
- R3: The unlock sequence is PAT_LEN consecutive read cycles. On read i (0-based), the nibble `addr[18:15]` must equal `UNLOCK_PAT[4*i +: 4]`.
- R4: During the unlock or load phase, a write cycle or a mismatching read returns the matcher to the start. The mismatching read does not count as step 1, and the whole sequence must be sent again.
- R5: After a full match, load read k (k = 0..3) writes protect bits 4k..4k+3 from `addr[15]` (lowest bit) up to `addr[18]` (highest bit). After load read 3 the matcher returns to the start, so a later full sequence overwrites all 16 bits.
- R6: `ram_we_n` is 1 whenever the protect bit indexed by `addr[18:15]` is 1. When that bit is 0, `ram_we_n` equals `we_n` in the same cycle. A protect bit of 1 means the partition is write-protected.
- R7: While `pwr_fail` is 1, `ram_we_n` is 1 and `dout_en` is 0 in the same cycle. `pwr_warn` follows `pwr_fail` two clock edges later. While the synchronized power-fail flag is high, the matcher is held at the start.
- R8: `dout_en` is 1 exactly when `ce_n` and `oe_n` are 0, `we_n` is 1 and `pwr_fail` is 0. A low `we_n` disables the drivers even with `ce_n` and `oe_n` low.
- R9: The protect bits change only on load reads. Writes to protected partitions, ignored cycles and power failures leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| addr | input | ADDR_W | Bus address; top 4 bits select the partition |
| pwr_fail | input | 1 | Supply out of tolerance, active high |
| ram_we_n | output | 1 | Gated write enable to the RAM, active low |
| dout_en | output | 1 | Qualifier enabling the RAM data drivers |
| pwr_warn | output | 1 | Synchronized power-fail warning |

## Verification
The write gate and the driver qualifier are combinational from the live pins and the protect bits. The bench therefore checks them two nanoseconds after it drives the inputs, within the same clock cycle. A completed bus cycle takes effect three clock edges after `ce_n` rises: two synchronizer edges and then the matcher register. Each bus-cycle task therefore idles four clocks with chip enable high before the next probe. `pwr_warn` is due two edges after `pwr_fail` changes, and it is sampled after three. The protect map is read back only through `ram_we_n`, by driving `we_n` low with `ce_n` high. Such probes form no bus cycle and leave the matcher undisturbed.

// File: rtl/partprot_pkg.sv
package partprot_pkg;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

  localparam int unsigned PART_W_DEF  = 4;
  localparam int unsigned PAT_LEN_DEF = 20;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pp_cycle.sv
module pp_cycle
  import partprot_pkg::*;
#(
  parameter int unsigned PART_W = PART_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic [PART_W-1:0] nib_in,
  output logic              cyc_valid,
  output cyc_kind_e         cyc_kind,
  output logic [PART_W-1:0] cyc_nib
);
  logic              ce_q, rd_q, wr_q;
  logic              rd_d, wr_d;
  logic [PART_W-1:0] nib_q, nib_d;
  logic              end_evt;

  assign end_evt = ce_s & ~ce_q;

  // accumulate strobe activity while CE is low
  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    nib_d = nib_q;
    if (!ce_s) begin
      rd_d  = rd_q | ~oe_s;
      wr_d  = wr_q | ~we_s;
      nib_d = nib_in;
    end else begin
      rd_d = 1'b0;
      wr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      nib_q <= '0;
    end else begin
      ce_q  <= ce_s;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      nib_q <= nib_d;
    end
  end

  assign cyc_valid = end_evt & (rd_q | wr_q);
  assign cyc_kind  = wr_q ? CYC_WRITE : (rd_q ? CYC_READ : CYC_NONE);
  assign cyc_nib   = nib_q;

  // R2: a single CE pulse yields at most one cycle event
  a_r2_one_event_per_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);
endmodule

// File: rtl/pp_unlock.sv
module pp_unlock
  import partprot_pkg::*;
#(
  parameter int unsigned PART_W  = PART_W_DEF,
  parameter int unsigned PAT_LEN = PAT_LEN_DEF,
  parameter logic [PAT_LEN*PART_W-1:0] UNLOCK_PAT = '0,
  localparam int unsigned PROT_W = 1 << PART_W,
  localparam int unsigned LOADS  = PROT_W / PART_W,
  localparam int unsigned STEPS  = PAT_LEN + LOADS,
  localparam int unsigned SW     = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  cyc_kind_e         cyc_kind,
  input  logic [PART_W-1:0] cyc_nib,
  input  logic              pf_s,
  output logic [PROT_W-1:0] prot
);
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);
  localparam logic [SW-1:0] PAT_END   = SW'(PAT_LEN);

  logic [SW-1:0]     step_q, step_d;
  logic [PROT_W-1:0] prot_q, prot_d;
  logic [SW-1:0]     pat_idx;
  logic [PART_W-1:0] want_nib;
  logic              in_load;
  logic [SW-1:0]     load_idx;
  logic              is_rd, is_wr;

  assign is_rd    = cyc_valid && (cyc_kind == CYC_READ);
  assign is_wr    = cyc_valid && (cyc_kind == CYC_WRITE);
  assign in_load  = (step_q >= PAT_END);
  assign pat_idx  = in_load ? '0 : step_q;
  assign want_nib = UNLOCK_PAT[pat_idx*PART_W +: PART_W];
  assign load_idx = in_load ? (step_q - PAT_END) : '0;

  always_comb begin
    step_d = step_q;
    prot_d = prot_q;
    if (pf_s) begin
      step_d = '0;
    end else if (is_wr) begin
      step_d = '0;
    end else if (is_rd) begin
      if (!in_load) begin
        step_d = (cyc_nib == want_nib) ? step_q + 1'b1 : '0;
      end else begin
        for (int g = 0; g < int'(LOADS); g++) begin
          if (load_idx == SW'(g)) prot_d[g*PART_W +: PART_W] = cyc_nib;
        end
        step_d = (step_q == LAST_STEP) ? '0 : step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      prot_q <= '0;
    end else begin
      step_q <= step_d;
      prot_q <= prot_d;
    end
  end

  assign prot = prot_q;

  // R4: a write cycle always sends the matcher back to the start
  a_r4_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> (step_q == '0));
  // R3: the step counter never leaves its range
  a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);
  // R9: protect bits move only on a load read
  a_r9_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_rd && in_load && !pf_s) |=> $stable(prot_q));
  // R7: synchronized power fail holds the matcher at the start
  a_r7_pf_clears_step: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> (step_q == '0));
endmodule

// File: rtl/pp_gate.sv
module pp_gate #(
  parameter int unsigned PART_W = 4,
  localparam int unsigned PROT_W = 1 << PART_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [PART_W-1:0] part,
  input  logic [PROT_W-1:0] prot,
  input  logic              pwr_fail,
  output logic              ram_we_n,
  output logic              dout_en
);
  logic blocked;

  assign blocked  = prot[part] | pwr_fail;
  assign ram_we_n = we_n | blocked;
  assign dout_en  = ~ce_n & ~oe_n & we_n & ~pwr_fail;

  // R7: power failure locks writes and drivers
  a_r7_pf_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (ram_we_n && !dout_en));
  // R8: a low write enable never coexists with enabled drivers
  a_r8_we_disables: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_en);
endmodule

// File: rtl/partprot_ctrl.sv
module partprot_ctrl
  import partprot_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned PART_W  = PART_W_DEF,
  parameter int unsigned PAT_LEN = PAT_LEN_DEF,
  parameter logic [PAT_LEN*PART_W-1:0] UNLOCK_PAT = 80'h5A3C96E10F7B2D84C6E9,
  localparam int unsigned PROT_W = 1 << PART_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pwr_fail,
  output logic              ram_we_n,
  output logic              dout_en,
  output logic              pwr_warn
);
  logic              rst_meta, rst_sync;
  logic [3:0]        strb_s;
  logic              pf_s;
  logic [PART_W-1:0] part;
  logic              cyc_valid;
  cyc_kind_e         cyc_kind;
  logic [PART_W-1:0] cyc_nib;
  logic [PROT_W-1:0] prot;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign part = addr[ADDR_W-1 -: PART_W];

  pp_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync),
    .d     ({pwr_fail, we_n, oe_n, ce_n}),
    .q     (strb_s)
  );
  assign pf_s     = strb_s[3];
  assign pwr_warn = pf_s;

  pp_cycle #(.PART_W(PART_W)) u_cycle (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ce_s      (strb_s[0]),
    .oe_s      (strb_s[1]),
    .we_s      (strb_s[2]),
    .nib_in    (part),
    .cyc_valid (cyc_valid),
    .cyc_kind  (cyc_kind),
    .cyc_nib   (cyc_nib)
  );

  pp_unlock #(.PART_W(PART_W), .PAT_LEN(PAT_LEN), .UNLOCK_PAT(UNLOCK_PAT)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_sync),
    .cyc_valid (cyc_valid),
    .cyc_kind  (cyc_kind),
    .cyc_nib   (cyc_nib),
    .pf_s      (pf_s),
    .prot      (prot)
  );

  pp_gate #(.PART_W(PART_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_sync),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .part     (part),
    .prot     (prot),
    .pwr_fail (pwr_fail),
    .ram_we_n (ram_we_n),
    .dout_en  (dout_en)
  );

  // R1: no protection directly after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(rst_sync) |-> (prot == '0));
endmodule

// File: tb/sim_partprot_ctrl.sv
`timescale 1ns/1ps
module sim_partprot_ctrl;
  localparam logic [79:0] PAT = 80'h5A3C96E10F7B2D84C6E9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, we_n, pwr_fail;
  logic [18:0] addr;
  logic        ram_we_n, dout_en, pwr_warn;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_map;

  always #4 clk = ~clk;

  partprot_ctrl #(.UNLOCK_PAT(PAT)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .pwr_fail(pwr_fail),
    .ram_we_n(ram_we_n), .dout_en(dout_en), .pwr_warn(pwr_warn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // one bus cycle: rd/wr select strobes; neither gives an idle CE pulse
  task automatic bus_cyc(input logic rd, input logic wr, input logic [3:0] nib);
    @(negedge clk);
    addr = {nib, 15'h1234};
    ce_n = 1'b0; oe_n = ~rd; we_n = ~wr;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_pat(input int from, input int upto);
    for (int i = from; i < upto; i++) bus_cyc(1'b1, 1'b0, PAT[i*4 +: 4]);
  endtask

  task automatic send_loads(input logic [15:0] v);
    for (int k = 0; k < 4; k++) bus_cyc(1'b1, 1'b0, v[k*4 +: 4]);
  endtask

  // probe protect map via ram_we_n, with CE high so no cycle forms
  task automatic check_map(input string req);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      addr = {p[3:0], 15'h0};
      we_n = 1'b0;
      #2;
      chk(req, {31'b0, ram_we_n}, {31'b0, exp_map[p]});
      we_n = 1'b1;
    end
  endtask

  task automatic t_reset;
    exp_map = 16'h0000;
    chk("R1 pwr_warn", {31'b0, pwr_warn}, 0);
    chk("R1 dout_en idle", {31'b0, dout_en}, 0);
    check_map("R1 map after reset");
  endtask

  task automatic t_drivers;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #2 chk("R8 read drive", {31'b0, dout_en}, 1);
    we_n = 1'b0;
    #1 chk("R8 we low disables", {31'b0, dout_en}, 0);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_program(input logic [15:0] v, input string req);
    send_pat(0, 20);
    send_loads(v);
    exp_map = v;
    check_map(req);
  endtask

  task automatic t_protected_writes;
    for (int p = 0; p < 16; p++) bus_cyc(1'b0, 1'b1, p[3:0]);
    check_map("R9 writes leave map");
  endtask

  task automatic t_mismatch;
    send_pat(0, 10);
    bus_cyc(1'b1, 1'b0, PAT[40 +: 4] ^ 4'h1);
    send_pat(11, 20);
    send_loads(16'hFFFF);
    check_map("R4 mismatch restarts");
  endtask

  task automatic t_write_abort;
    send_pat(0, 15);
    bus_cyc(1'b0, 1'b1, 4'h0);
    send_pat(15, 20);
    send_loads(16'h0000);
    check_map("R4 write aborts unlock");
  endtask

  task automatic t_idle_cycle;
    send_pat(0, 5);
    bus_cyc(1'b0, 1'b0, 4'h3);
    send_pat(5, 20);
    send_loads(16'h0F0F);
    exp_map = 16'h0F0F;
    check_map("R2 idle pulse ignored");
  endtask

  task automatic t_pwrfail;
    @(negedge clk);
    addr = {4'h4, 15'h0};
    pwr_fail = 1'b1; we_n = 1'b0;
    #2 chk("R7 write locked", {31'b0, ram_we_n}, 1);
    we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    #1 chk("R7 drivers off", {31'b0, dout_en}, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 warning", {31'b0, pwr_warn}, 1);
    pwr_fail = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 warning clears", {31'b0, pwr_warn}, 0);
    send_pat(0, 10);
    @(negedge clk) pwr_fail = 1'b1;
    repeat (4) @(negedge clk);
    pwr_fail = 1'b0;
    repeat (4) @(negedge clk);
    send_pat(10, 20);
    send_loads(16'hFFFF);
    check_map("R7 power fail resets matcher");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    pwr_fail = 1'b0; addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_drivers();
    t_program(16'hA5C3, "R3 R5 R6 program map");
    t_protected_writes();
    t_mismatch();
    t_write_abort();
    t_program(16'h1234, "R5 reprogram overwrites");
    t_idle_cycle();
    t_pwrfail();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule